// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits beside a 32-bit configuration word stream and watches the first few hundred words as they go by. Two header words tell it whether the image is protected and whether it is packed. From those two flags and the selected bus width (16 or 32 bits), it works out the clock-to-data ratio code and the width select that the parallel configuration datapath must use for the rest of the load.

A start pulse arms the block, samples the declared stream length and samples the width mode. Every accepted word after the start advances a word index that begins at 0. The block refuses streams declared too short to hold both header fields. It also refuses streams that end early. In both cases it raises an error instead of done. Once the decision is made, the ratio and width outputs stay fixed until the next start pulse.

Top module: `hdrRatioSel`

## Requirements
- R1: After reset, `done`, `err`, `ratioCode` and `widthSel` are all 0.
- R2: If `start` is high and `streamLen` is below 230, `err` is 1 and `done` is 0 from the next cycle on. Later words are then ignored.
- R3: The protection flag is true when bits [3:2] of the word at index 69 are not both zero. The index counts accepted words from 0, beginning with the first word after the start pulse.
- R4: The packing flag is true when bit 1 of the word at index 229 is 0.
- R5: When neither flag is true, `ratioCode` is 0 (x1) in both width modes. The codes are x1=0, x2=1, x4=2, x8=3.
- R6: With `wideMode`=0 (16-bit), a packed image gives code 2 whether it is protected or not. A protected but unpacked image gives code 1. `widthSel` is then 0.
- R7: With `wideMode`=1 (32-bit), a packed image gives code 3 and a protected but unpacked image gives code 2. `widthSel` is then 1.
- R8: `done` rises in the cycle after the clock edge that accepts word 229. `ratioCode`, `widthSel` and `done` then hold steady through any further words until the next `start`.
- R9: If `wordLast` comes with an accepted word whose index is below 229, `err` rises in the next cycle and `done` stays 0. If `wordLast` comes with word 229 itself, `done` rises and `err` stays 0.
- R10: A `start` pulse clears `done`, `err`, `ratioCode` and `widthSel` at the next edge, even in the middle of a stream. A word presented in the same cycle as `start` is not counted.
- R11: Cycles with `wordValid` low do not advance the word index, whatever `wordData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that arms a new check |
| streamLen | input | LEN_W | Declared stream length in words, sampled on `start` |
| wideMode | input | 1 | 1 selects 32-bit width, 0 selects 16-bit; sampled on `start` |
| wordValid | input | 1 | A word is present on `wordData` |
| wordData | input | 32 | Stream word |
| wordLast | input | 1 | The present word is the last of the stream |
| ratioCode | output | 2 | Clock-to-data ratio code (x1=0, x2=1, x4=2, x8=3) |
| widthSel | output | 1 | Width select for the datapath, 1 for 32-bit |
| done | output | 1 | Decision made; outputs are valid |
| err | output | 1 | Check refused (stream declared or found too short) |

## Verification
Stream end and the decision word can land on the same clock edge. When `wordLast` comes with word 229, the capture of the packing flag and the end of stream happen together. The bench provokes this with a stream exactly 230 words long and expects done with no error and the correct code. It then moves the last flag one word earlier and expects an error with done low. A start pulse that carries a word in the same cycle is also exercised. Header words are surrounded by fillers carrying the opposite flag values, so any shift in the word index shows up as a wrong ratio code.

// File: rtl/hdrPkg.sv
package hdrPkg;

  // ratio encodings
  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;
  localparam logic [1:0] RATIO_X8 = 2'd3;

  // control-to-datapath strobes
  typedef struct packed {
    logic arm;      // new check: clear flags and outputs, sample width mode
    logic capEnc;   // capture protection field from current word
    logic capComp;  // capture packing field and commit ratio/width
  } hdrStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_FAIL = 2'd3
  } hdrState_t;

endpackage

// File: rtl/hdrCtrl.sv
module hdrCtrl
  import hdrPkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int ENC_WORD  = 69,
  parameter int COMP_WORD = 229,
  parameter int MIN_LEN   = 230
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] streamLen,
  input  logic             wordValid,
  input  logic             wordLast,
  output hdrStrobe_t       strobe,
  output logic             done,
  output logic             err
);

  localparam int CNT_W = $clog2(COMP_WORD + 1);

  hdrState_t        state;
  logic [CNT_W-1:0] wordIdx;
  logic             takeWord;
  logic             lenShort;

  assign lenShort = streamLen < LEN_W'(MIN_LEN);
  assign takeWord = (state == ST_RUN) && wordValid && !start;

  always_comb begin
    strobe.arm     = start;
    strobe.capEnc  = takeWord && (wordIdx == CNT_W'(ENC_WORD));
    strobe.capComp = takeWord && (wordIdx == CNT_W'(COMP_WORD));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else if (start) begin
      state   <= lenShort ? ST_FAIL : ST_RUN;
      wordIdx <= '0;
    end else if (takeWord) begin
      if (wordIdx == CNT_W'(COMP_WORD)) begin
        state <= ST_FIN;
      end else if (wordLast) begin
        state <= ST_FAIL;
      end else begin
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  assign done = (state == ST_FIN);
  assign err  = (state == ST_FAIL);

endmodule

// File: rtl/hdrPath.sv
module hdrPath
  import hdrPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ENC_LO   = 2,
  parameter int ENC_HI   = 3,
  parameter int COMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdrStrobe_t        strobe,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] wordData,
  output logic [1:0]        ratioCode,
  output logic              widthSel
);

  logic       encFlag;
  logic       modeWide;
  logic       compNow;
  logic [1:0] ratioNext;

  assign compNow = ~wordData[COMP_BIT];

  always_comb begin
    if (!compNow && !encFlag) begin
      ratioNext = RATIO_X1;
    end else begin
      ratioNext = (compNow ? RATIO_X4 : RATIO_X2) + {1'b0, modeWide};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encFlag   <= 1'b0;
      modeWide  <= 1'b0;
      ratioCode <= RATIO_X1;
      widthSel  <= 1'b0;
    end else if (strobe.arm) begin
      encFlag   <= 1'b0;
      modeWide  <= wideMode;
      ratioCode <= RATIO_X1;
      widthSel  <= 1'b0;
    end else begin
      if (strobe.capEnc) begin
        encFlag <= |wordData[ENC_HI:ENC_LO];
      end
      if (strobe.capComp) begin
        ratioCode <= ratioNext;
        widthSel  <= modeWide;
      end
    end
  end

endmodule

// File: rtl/hdrRatioSel.sv
module hdrRatioSel
  import hdrPkg::*;
#(
  parameter int LEN_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ENC_WORD  = 69,
  parameter int COMP_WORD = 229,
  parameter int MIN_LEN   = COMP_WORD + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  streamLen,
  input  logic              wideMode,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  input  logic              wordLast,
  output logic [1:0]        ratioCode,
  output logic              widthSel,
  output logic              done,
  output logic              err
);

  hdrStrobe_t strobe;

  hdrCtrl #(
    .LEN_W(LEN_W), .ENC_WORD(ENC_WORD), .COMP_WORD(COMP_WORD), .MIN_LEN(MIN_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .streamLen(streamLen),
    .wordValid(wordValid), .wordLast(wordLast), .strobe(strobe),
    .done(done), .err(err)
  );

  hdrPath #(
    .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wideMode(wideMode),
    .wordData(wordData), .ratioCode(ratioCode), .widthSel(widthSel)
  );

endmodule

// File: rtl/hdrRatioSel_chk.sv
module hdrRatioSel_chk #(
  parameter int LEN_W   = 32,
  parameter int MIN_LEN = 230
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] streamLen,
  input logic             wordValid,
  input logic             wordLast,
  input logic [1:0]       ratioCode,
  input logic             widthSel,
  input logic             done,
  input logic             err
);

  assert_short_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && (streamLen < LEN_W'(MIN_LEN)) |=> err && !done);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    start && (streamLen >= LEN_W'(MIN_LEN)) |=> !err && !done && ratioCode == 2'd0 && !widthSel);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(ratioCode) && $stable(widthSel));

  assert_narrow_no_x8_R6: assert property (@(posedge clk) disable iff (!rstN)
    done && !widthSel |-> ratioCode != 2'd3);

  assert_wide_no_x2_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && widthSel |-> ratioCode != 2'd1);

  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  assert_early_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) && !$past(start) |-> $past(wordValid && wordLast));

endmodule

bind hdrRatioSel hdrRatioSel_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .streamLen(streamLen),
  .wordValid(wordValid), .wordLast(wordLast), .ratioCode(ratioCode),
  .widthSel(widthSel), .done(done), .err(err)
);

// File: tb/hdrRatioSel_tb.sv
`timescale 1ns/1ps
module hdrRatioSel_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] streamLen = '0;
  logic        wideMode = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordLast = 1'b0;
  logic [1:0]  ratioCode;
  logic        widthSel;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hdrRatioSel u_dut (
    .clk(clk), .rstN(rstN), .start(start), .streamLen(streamLen),
    .wideMode(wideMode), .wordValid(wordValid), .wordData(wordData),
    .wordLast(wordLast), .ratioCode(ratioCode), .widthSel(widthSel),
    .done(done), .err(err)
  );

  // {wide, encBits[1:0], compBit, expRatio[1:0]}
  localparam logic [5:0] VEC [8] = '{
    {1'b0, 2'b00, 1'b1, 2'd0},
    {1'b0, 2'b00, 1'b0, 2'd2},
    {1'b0, 2'b01, 1'b1, 2'd1},
    {1'b0, 2'b10, 1'b0, 2'd2},
    {1'b1, 2'b00, 1'b1, 2'd0},
    {1'b1, 2'b00, 1'b0, 2'd3},
    {1'b1, 2'b11, 1'b1, 2'd2},
    {1'b1, 2'b10, 1'b0, 2'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(int idx, logic [1:0] encBits, bit compBit);
    logic [31:0] w;
    w = 32'hA5A5_A5A0;
    w[3:2] = (encBits == 2'b00) ? 2'b11 : 2'b00;
    w[1]   = compBit ? 1'b0 : 1'b1;
    if (idx == 69)  w[3:2] = encBits;
    if (idx == 229) w[1]   = compBit;
    return w;
  endfunction

  task automatic doStart(int len, bit wide, bit withWord, logic [1:0] encBits, bit compBit);
    @(negedge clk);
    start = 1'b1; streamLen = len; wideMode = wide;
    wordValid = withWord;
    wordData  = withWord ? mkWord(69, encBits, compBit) : '0;
    wordLast  = 1'b0;
    @(negedge clk);
    start = 1'b0; wordValid = 1'b0;
  endtask

  // sends words 0..nWords-1; this task is entered at a negedge
  task automatic sendWords(int nWords, int lastAt, logic [1:0] encBits, bit compBit, bit gaps);
    for (int i = 0; i < nWords; i++) begin
      wordValid = 1'b1;
      wordData  = mkWord(i, encBits, compBit);
      wordLast  = (i == lastAt);
      @(negedge clk);
      if (gaps && (i % 7 == 3)) begin
        wordValid = 1'b0;
        wordData  = mkWord(i == 68 ? 69 : 229, encBits, compBit);
        wordLast  = 1'b1;
        @(negedge clk);
      end
    end
    wordValid = 1'b0; wordLast = 1'b0; wordData = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 ratio", ratioCode, 0);
    chk("R1 width", widthSel, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table of flag/width combinations: R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      doStart(235, VEC[k][5], 1'b0, 2'b00, 1'b0);
      sendWords(235, 234, VEC[k][4:3], VEC[k][2], 1'b0);
      chk($sformatf("R3/R4/R5/R6/R7 ratio vec%0d", k), ratioCode, VEC[k][1:0]);
      chk($sformatf("R6/R7 width vec%0d", k), widthSel, VEC[k][5]);
      chk($sformatf("R8 done vec%0d", k), done, 1);
      chk($sformatf("R9 err vec%0d", k), err, 0);
    end

    // R8: done timing exactly after word 229
    doStart(300, 1'b1, 1'b0, 2'b00, 1'b0);
    sendWords(229, -1, 2'b01, 1'b1, 1'b0);
    chk("R8 done before word 229", done, 0);
    wordValid = 1'b1; wordData = mkWord(229, 2'b01, 1'b1); wordLast = 1'b0;
    @(negedge clk);
    wordValid = 1'b0;
    chk("R8 done after word 229", done, 1);
    chk("R8 ratio after word 229", ratioCode, 2);
    // later words with opposite flags must not disturb outputs
    sendWords(20, 19, 2'b00, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 ratio held", ratioCode, 2);
    chk("R8 width held", widthSel, 1);

    // R10: start clears outputs
    doStart(235, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R10 done cleared", done, 0);
    chk("R10 ratio cleared", ratioCode, 0);
    chk("R10 width cleared", widthSel, 0);

    // R2: declared length below minimum
    doStart(229, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R2 err short", err, 1);
    chk("R2 done short", done, 0);
    sendWords(235, 234, 2'b00, 1'b0, 1'b0);
    chk("R2 still refused", done, 0);
    chk("R2 ratio untouched", ratioCode, 0);

    // R9: stream ends on word 228
    doStart(230, 1'b1, 1'b0, 2'b00, 1'b0);
    sendWords(229, 228, 2'b00, 1'b0, 1'b0);
    chk("R9 early end err", err, 1);
    chk("R9 early end done", done, 0);

    // R9: stream ends exactly on word 229 (boundary length 230)
    doStart(230, 1'b0, 1'b0, 2'b00, 1'b0);
    sendWords(230, 229, 2'b10, 1'b1, 1'b0);
    chk("R9 last on 229 done", done, 1);
    chk("R9 last on 229 err", err, 0);
    chk("R9 last on 229 ratio", ratioCode, 1);

    // R10: restart mid-stream, word in start cycle not counted
    doStart(235, 1'b0, 1'b0, 2'b00, 1'b0);
    sendWords(100, -1, 2'b11, 1'b0, 1'b0);
    doStart(235, 1'b1, 1'b1, 2'b00, 1'b1);
    chk("R10 restart done low", done, 0);
    sendWords(235, 234, 2'b00, 1'b1, 1'b0);
    chk("R10 restart ratio", ratioCode, 0);
    chk("R10 restart done", done, 1);

    // R11: idle cycles with misleading data do not count
    doStart(235, 1'b1, 1'b0, 2'b00, 1'b0);
    sendWords(235, 234, 2'b01, 1'b1, 1'b1);
    chk("R11 gaps ratio", ratioCode, 2);
    chk("R11 gaps done", done, 1);
    chk("R11 gaps err", err, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule